// File: doc/BRIEF.md
# Prefix-Aware Segment Selection Unit

This unit sits beside the instruction byte stream of a 16-bit segmented core. It takes one byte per valid cycle and keeps a pending segment override when a prefix byte of that kind appears ahead of an instruction. For each memory operand it picks the segment register. The choice depends, in priority order, on the operand class (implicit stack access or string destination), then on any pending override, then on the base register that the address decoder reports. It then forms the 20-bit physical address from the picked segment value and the 16-bit effective offset.

Operand resolution is combinational. It uses the registered override state and the current operand inputs, so an operand that the decoder presents with the opcode byte sees the override that its own prefixes set up. The opcode byte is the first byte that is neither a segment override, a bus-lock prefix nor a repeat prefix. Consuming that byte clears the pending override from the next cycle on. Bus-lock and repeat prefix bytes may sit between or around override bytes without disturbing them.

Top module: `seg_select_unit`

## Requirements
- R1: A consumed byte whose bits [7:5] are 001 and bits [2:0] are 110 (0x26, 0x2E, 0x36, 0x3E) is a segment override. From the next cycle on it selects, through bits [4:3], code 00=ES, 01=CS, 10=SS or 11=DS for ordinary operands, and `seg_code` carries that same 2-bit code. A byte such as 0x27 that has any other bit pattern is not taken as an override.
- R2: With no override pending, an ordinary operand uses DS (code 11) when base_sel is 01 (BX), 00 (no base, index alone or direct address) or the spare value 11, with or without an index.
- R3: With no override pending, an ordinary operand uses SS (code 10) when base_sel is 10 (BP), whether an index is used or not.
- R4: When stack_op is 1 the result is SS and ovr_used is 0, whatever the override state and str_dst.
- R5: When str_dst is 1 and stack_op is 0 the result is ES (code 00) and ovr_used is 0, whatever the override state.
- R6: When two override bytes arrive before the opcode, the later one decides the segment.
- R7: The bytes 0xF0 (bus lock), 0xF2 and 0xF3 (repeat) leave a pending override and its code unchanged.
- R8: Any other consumed byte clears the pending override from the following cycle on. An operand resolved in the same cycle as that byte still uses the override.
- R9: phys_addr equals the selected segment value times 16 plus eff_offset, modulo 2^20.
- R10: ovr_used is 1 exactly when a pending override decided the segment of the current operand.
- R11: After reset, no override is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | A byte is consumed this cycle |
| byte_data | input | 8 | Consumed instruction byte |
| base_sel | input | 2 | Base register of operand: 00 none, 01 BX, 10 BP, 11 spare |
| index_used | input | 1 | Operand address uses an index register |
| str_dst | input | 1 | Operand is a string destination addressed through DI |
| stack_op | input | 1 | Operand is an implicit stack access |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| eff_offset | input | 16 | Effective offset of operand |
| seg_code | output | 2 | Selected segment code (00 ES, 01 CS, 10 SS, 11 DS) |
| phys_addr | output | 20 | Physical address |
| ovr_used | output | 1 | A pending override decided the segment |

## Verification
Operand resolution and override clearing coincide in the cycle where the opcode byte is consumed. The resolution must still see the override, and the clear must only take effect afterwards. The bench provokes this for every prefix code, every base and index combination and both forced classes. It checks the outputs in the opcode cycle against the override-based expectation, then checks one cycle later that the same operand falls back to its default segment. Directed cases mix lock and repeat bytes into prefix runs, use back-to-back overrides and force an address wrap-around.

// File: rtl/seg_sel_pkg.sv
// Package: shared codes and constants of the segment selection unit.
// Assumes a 2-bit segment code space and 8-bit instruction bytes.
package seg_sel_pkg;
    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_t;

    localparam logic [1:0] BASE_NONE  = 2'b00;
    localparam logic [1:0] BASE_BX    = 2'b01;
    localparam logic [1:0] BASE_BP    = 2'b10;
    localparam logic [1:0] BASE_SPARE = 2'b11;

    localparam logic [7:0] BYTE_LOCK  = 8'hF0;
    localparam logic [7:0] BYTE_REPNE = 8'hF2;
    localparam logic [7:0] BYTE_REPE  = 8'hF3;

    localparam int NUM_SEGS = 4;
endpackage

// File: rtl/seg_prefix_tracker.sv
// Module: seg_prefix_tracker
// Holds the segment override seen in the current prefix run. Override
// bytes load it, lock/repeat bytes keep it, any other byte clears it.
// Assumes byte_valid qualifies byte_data every cycle.
module seg_prefix_tracker
    import seg_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       ovr_pending,
    output seg_code_t  ovr_code
);
    logic is_ovr_byte;
    logic is_keep_byte;

    // Classify the incoming byte.
    always_comb begin
        is_ovr_byte  = (byte_data[7:5] == 3'b001) && (byte_data[2:0] == 3'b110);
        is_keep_byte = (byte_data == BYTE_LOCK) || (byte_data == BYTE_REPNE) ||
                       (byte_data == BYTE_REPE);
    end

    // Update the pending override on every consumed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pending <= 1'b0;
            ovr_code    <= SEG_DS;
        end else if (byte_valid) begin
            if (is_ovr_byte) begin
                ovr_pending <= 1'b1;
                ovr_code    <= seg_code_t'(byte_data[4:3]);
            end else if (!is_keep_byte) begin
                ovr_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/seg_source_picker.sv
// Module: seg_source_picker
// Chooses the segment for one operand: forced classes first (stack, then
// string destination), then a pending override, then the base default.
// Assumes at most one base register is reported per operand.
module seg_source_picker
    import seg_sel_pkg::*;
(
    input  logic [1:0] base_sel,
    input  logic       index_used,
    input  logic       str_dst,
    input  logic       stack_op,
    input  logic       ovr_pending,
    input  seg_code_t  ovr_code,
    output seg_code_t  seg_code,
    output logic       ovr_applied
);
    seg_code_t dflt_code;

    // Default segment from the base register; the index never decides it.
    always_comb begin
        case ({base_sel, index_used})
            {BASE_BP, 1'b0},
            {BASE_BP, 1'b1}:    dflt_code = SEG_SS;
            {BASE_BX, 1'b0},
            {BASE_BX, 1'b1}:    dflt_code = SEG_DS;
            {BASE_NONE, 1'b1}:  dflt_code = SEG_DS;
            {BASE_NONE, 1'b0}:  dflt_code = SEG_DS;
            default:            dflt_code = SEG_DS;
        endcase
    end

    // Priority resolution of the final segment.
    always_comb begin
        ovr_applied = 1'b0;
        if (stack_op) begin
            seg_code = SEG_SS;
        end else if (str_dst) begin
            seg_code = SEG_ES;
        end else if (ovr_pending) begin
            seg_code    = ovr_code;
            ovr_applied = 1'b1;
        end else begin
            seg_code = dflt_code;
        end
    end
endmodule

// File: rtl/seg_addr_former.sv
// Module: seg_addr_former
// Muxes the selected segment value and forms segment*2^SHIFT + offset,
// truncated to PA_W bits. Assumes PA_W is at least SEG_W+SHIFT or the
// upper segment bits are dropped on purpose.
module seg_addr_former
    import seg_sel_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input  seg_code_t           seg_code,
    input  logic [SEG_W-1:0]    seg_es,
    input  logic [SEG_W-1:0]    seg_cs,
    input  logic [SEG_W-1:0]    seg_ss,
    input  logic [SEG_W-1:0]    seg_ds,
    input  logic [OFS_W-1:0]    eff_offset,
    output logic [PA_W-1:0]     phys_addr
);
    localparam int SUM_W = ((SEG_W + SHIFT) > OFS_W ? (SEG_W + SHIFT) : OFS_W) + 1;

    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_tab;
    logic [SEG_W-1:0]               seg_val;
    logic [SUM_W-1:0]               sum;

    // Arrange the segment values by code.
    generate
        for (genvar g = 0; g < NUM_SEGS; g++) begin : g_tab
            if (g == int'(SEG_ES))      begin : g_es assign seg_tab[g] = seg_es; end
            else if (g == int'(SEG_CS)) begin : g_cs assign seg_tab[g] = seg_cs; end
            else if (g == int'(SEG_SS)) begin : g_ss assign seg_tab[g] = seg_ss; end
            else                        begin : g_ds assign seg_tab[g] = seg_ds; end
        end
    endgenerate

    // Select the segment and add the scaled value to the offset.
    always_comb begin
        seg_val   = seg_tab[seg_code];
        sum       = (SUM_W'(seg_val) << SHIFT) + SUM_W'(eff_offset);
        phys_addr = sum[PA_W-1:0];
    end
endmodule

// File: rtl/seg_select_unit.sv
// Module: seg_select_unit (top)
// Tracks segment override prefixes on the byte stream and resolves the
// segment and physical address of the current memory operand. Operand
// inputs are assumed valid in the cycle the outputs are used.
module seg_select_unit
    import seg_sel_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [1:0]        base_sel,
    input  logic              index_used,
    input  logic              str_dst,
    input  logic              stack_op,
    input  logic [SEG_W-1:0]  seg_es,
    input  logic [SEG_W-1:0]  seg_cs,
    input  logic [SEG_W-1:0]  seg_ss,
    input  logic [SEG_W-1:0]  seg_ds,
    input  logic [OFS_W-1:0]  eff_offset,
    output logic [1:0]        seg_code,
    output logic [PA_W-1:0]   phys_addr,
    output logic              ovr_used
);
    logic      ovr_pending;
    seg_code_t ovr_code;
    seg_code_t sel_code;

    seg_prefix_tracker trk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .ovr_pending (ovr_pending),
        .ovr_code    (ovr_code)
    );

    seg_source_picker pick_i (
        .base_sel    (base_sel),
        .index_used  (index_used),
        .str_dst     (str_dst),
        .stack_op    (stack_op),
        .ovr_pending (ovr_pending),
        .ovr_code    (ovr_code),
        .seg_code    (sel_code),
        .ovr_applied (ovr_used)
    );

    seg_addr_former #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .PA_W  (PA_W),
        .SHIFT (SHIFT)
    ) addr_i (
        .seg_code   (sel_code),
        .seg_es     (seg_es),
        .seg_cs     (seg_cs),
        .seg_ss     (seg_ss),
        .seg_ds     (seg_ds),
        .eff_offset (eff_offset),
        .phys_addr  (phys_addr)
    );

    // Drive the code output from the picker.
    assign seg_code = sel_code;
endmodule

// File: rtl/seg_select_checker.sv
// Module: seg_select_checker
// Port-level properties of seg_select_unit, attached by bind below.
module seg_select_checker #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic [7:0]        byte_data,
    input logic [1:0]        base_sel,
    input logic              str_dst,
    input logic              stack_op,
    input logic [SEG_W-1:0]  seg_es,
    input logic [SEG_W-1:0]  seg_cs,
    input logic [SEG_W-1:0]  seg_ss,
    input logic [SEG_W-1:0]  seg_ds,
    input logic [OFS_W-1:0]  eff_offset,
    input logic [1:0]        seg_code,
    input logic [PA_W-1:0]   phys_addr,
    input logic              ovr_used
);
    logic              is_ovr;
    logic              is_keep;
    logic [SEG_W-1:0]  chk_seg;
    logic [PA_W-1:0]   chk_pa;

    // Reference byte classes and the address the code implies.
    always_comb begin
        is_ovr  = (byte_data[7:5] == 3'b001) && (byte_data[2:0] == 3'b110);
        is_keep = (byte_data == 8'hF0) || (byte_data == 8'hF2) || (byte_data == 8'hF3);
        case (seg_code)
            2'b00:   chk_seg = seg_es;
            2'b01:   chk_seg = seg_cs;
            2'b10:   chk_seg = seg_ss;
            default: chk_seg = seg_ds;
        endcase
        chk_pa = PA_W'((PA_W + 1)'(chk_seg) << SHIFT) + PA_W'(eff_offset);
    end

    assert_pfx_apply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_ovr) |=>
        (stack_op || str_dst || (ovr_used && seg_code == $past(byte_data[4:3]))));

    assert_bx_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_used && !stack_op && !str_dst && base_sel != 2'b10) |-> (seg_code == 2'b11));

    assert_bp_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_used && !stack_op && !str_dst && base_sel == 2'b10) |-> (seg_code == 2'b10));

    assert_stack_ss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stack_op |-> (seg_code == 2'b10 && !ovr_used));

    assert_strdst_es_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (str_dst && !stack_op) |-> (seg_code == 2'b00 && !ovr_used));

    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_keep && ovr_used) |=>
        (stack_op || str_dst || (ovr_used && seg_code == $past(seg_code))));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !is_ovr && !is_keep) |=> !ovr_used);

    assert_phys_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr == chk_pa);
endmodule

bind seg_select_unit seg_select_checker #(
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .PA_W  (PA_W),
    .SHIFT (SHIFT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .base_sel   (base_sel),
    .str_dst    (str_dst),
    .stack_op   (stack_op),
    .seg_es     (seg_es),
    .seg_cs     (seg_cs),
    .seg_ss     (seg_ss),
    .seg_ds     (seg_ds),
    .eff_offset (eff_offset),
    .seg_code   (seg_code),
    .phys_addr  (phys_addr),
    .ovr_used   (ovr_used)
);

// File: tb/seg_select_unit_tb.sv
`timescale 1ns/1ps
// Bench: sweeps prefix code x base x index x forced class, plus directed
// cases for chains, lock/repeat bytes, wrap-around and reset.
module seg_select_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [1:0]  base_sel = 2'b00;
    logic        index_used = 1'b0;
    logic        str_dst = 1'b0;
    logic        stack_op = 1'b0;
    logic [15:0] seg_es = 16'h0000;
    logic [15:0] seg_cs = 16'h0000;
    logic [15:0] seg_ss = 16'h0000;
    logic [15:0] seg_ds = 16'h0000;
    logic [15:0] eff_offset = 16'h0000;
    logic [1:0]  seg_code;
    logic [19:0] phys_addr;
    logic        ovr_used;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    seg_select_unit dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .base_sel(base_sel), .index_used(index_used), .str_dst(str_dst),
        .stack_op(stack_op), .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss),
        .seg_ds(seg_ds), .eff_offset(eff_offset), .seg_code(seg_code),
        .phys_addr(phys_addr), .ovr_used(ovr_used)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    function automatic logic [15:0] seg_of(input logic [1:0] c);
        case (c)
            2'b00:   return seg_es;
            2'b01:   return seg_cs;
            2'b10:   return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    function automatic logic [19:0] pa_of(input logic [1:0] c);
        int unsigned v;
        v = (int'(seg_of(c)) * 16) + int'(eff_offset);
        return v[19:0];
    endfunction

    function automatic logic [1:0] dflt_of(input logic [1:0] b);
        return (b == 2'b10) ? 2'b10 : 2'b11;
    endfunction

    // Checks code, flag and address against an expected code and flag.
    task automatic check_all(input string req, input logic [1:0] ec, input logic eo);
        check({req, " code"}, 32'(seg_code), 32'(ec));
        check({req, " ovr_used R10"}, 32'(ovr_used), 32'(eo));
        check("R9 phys", 32'(phys_addr), 32'(pa_of(ec)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state, no override
        seg_ds = 16'h1234; eff_offset = 16'h0010;
        #1 check_all("R11 reset", 2'b11, 1'b0);

        // Exhaustive sweep: prefix (4 = none) x base x index x str_dst x stack_op
        for (int pf = 0; pf < 5; pf++) begin
            for (int b = 0; b < 4; b++) begin
                for (int ix = 0; ix < 2; ix++) begin
                    for (int sd = 0; sd < 2; sd++) begin
                        for (int sk = 0; sk < 2; sk++) begin
                            logic [1:0] ec;
                            logic eo;
                            k++;
                            send_byte(8'h90);
                            if (pf < 4) send_byte({3'b001, 2'(pf), 3'b110});
                            base_sel = 2'(b); index_used = ix[0];
                            str_dst = sd[0]; stack_op = sk[0];
                            seg_es = 16'(k * 16'h1357 + 16'h0100);
                            seg_cs = 16'(k * 16'h2468 + 16'h0200);
                            seg_ss = 16'(k * 16'h0F0F + 16'h0300);
                            seg_ds = 16'(k * 16'h7777 + 16'h0400);
                            eff_offset = 16'(k * 16'h9ABD);
                            if (sk != 0)      begin ec = 2'b10;      eo = 1'b0; end
                            else if (sd != 0) begin ec = 2'b00;      eo = 1'b0; end
                            else if (pf < 4)  begin ec = 2'(pf);     eo = 1'b1; end
                            else              begin ec = dflt_of(2'(b)); eo = 1'b0; end
                            #1;
                            if (sk != 0)      check_all("R4 stack", ec, eo);
                            else if (sd != 0) check_all("R5 strdst", ec, eo);
                            else if (pf < 4)  check_all("R1 override", ec, eo);
                            else if (b == 2)  check_all("R3 bp default", ec, eo);
                            else              check_all("R2 ds default", ec, eo);
                            // opcode consumed: same cycle still uses override (R8)
                            byte_valid = 1'b1; byte_data = 8'h8B;
                            #1 check_all("R8 same cycle", ec, eo);
                            @(negedge clk);
                            byte_valid = 1'b0; str_dst = 1'b0; stack_op = 1'b0;
                            #1 check_all("R8 cleared", dflt_of(2'(b)), 1'b0);
                        end
                    end
                end
            end
        end

        // R6: later override wins, even over BP default
        base_sel = 2'b10; index_used = 1'b1;
        send_byte(8'h90); send_byte(8'h26); send_byte(8'h3E);
        #1 check_all("R6 later wins", 2'b11, 1'b1);
        send_byte(8'h3E); send_byte(8'h36);
        #1 check_all("R6 later wins ss", 2'b10, 1'b1);

        // R7: lock and repeat bytes keep the override
        send_byte(8'h90); send_byte(8'h2E); send_byte(8'hF0); send_byte(8'hF3);
        #1 check_all("R7 lock/rep keep", 2'b01, 1'b1);
        send_byte(8'hF2);
        #1 check_all("R7 repne keep", 2'b01, 1'b1);
        send_byte(8'hF0); send_byte(8'h26);
        #1 check_all("R7 override after lock", 2'b00, 1'b1);

        // R1: near-prefix byte is not an override and clears
        send_byte(8'h27);
        #1 check_all("R1 non-prefix 0x27", 2'b10, 1'b0);
        base_sel = 2'b01;
        send_byte(8'h36); send_byte(8'h90);
        #1 check_all("R8 cleared next operand", 2'b11, 1'b0);

        // R9: wrap-around of the 20-bit address
        base_sel = 2'b00; index_used = 1'b0;
        seg_ds = 16'hFFFF; eff_offset = 16'hFFFF;
        #1 check("R9 wrap", 32'(phys_addr), 32'h0FFEF);
        seg_cs = 16'hF000; eff_offset = 16'h1234;
        send_byte(8'h2E);
        #1 check("R9 cs address", 32'(phys_addr), 32'hF1234);

        // R11: reset clears a pending override
        send_byte(8'h26);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check_all("R11 reset clears", 2'b11, 1'b0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule